// File: doc/BRIEF.md
# Configurable Subgraph Compute Array

This block evaluates a small dataflow graph of simple integer operations as one accelerated instruction. Each operation takes four 32-bit source operands and one wide configuration word, and returns two 32-bit results. The configuration word comes from a decode-time lookup table and travels with the instruction.

The datapath has five rows of function units. The rows alternate between arithmetic/logic units and logic-only units. Before each row, a crossbar lets every unit operand pick any array input or any result from an earlier row. Two output multiplexers choose the two results from the whole value pool. No unit can multiply, divide, access memory or branch. The datapath is purely combinational and ends in one register stage. A `valid_in`/`valid_out` pair marks operations, with a fixed one-cycle latency and a new operation accepted on every cycle.

Top module: `subgraph_array`

## Requirements
- R1: When `valid_in` is high on a clock edge, `valid_out` is high after that edge and `res0`/`res1` hold the results for the operands and configuration sampled at that edge. Operations may be issued on consecutive cycles.
- R2: A unit applies its 3-bit opcode to operands A and B as follows: 0 gives A, 1 gives A&B, 2 gives A|B, 3 gives A^B, 4 gives A&~B, 5 gives ~A, 6 gives A+B and 7 gives A-B. Codes 6 and 7 apply only on arithmetic rows.
- R3: On a logic-only unit, opcodes 6 and 7 return operand A unchanged.
- R4: Addition and subtraction wrap modulo 2^32.
- R5: The value pool is indexed as follows: 0-3 are `op_a`..`op_d`, 4-7 are row 0, 8-11 are row 1, 12-13 are row 2, 14-15 are row 3 and 16 is row 4. Each unit operand has a 4-bit select. A select that points at a value in the unit's own row or in any later row gives zero.
- R6: The row kinds and sizes are: row 0 has four arithmetic units, row 1 has four logic units, row 2 has two arithmetic units, row 3 has two logic units and row 4 has one arithmetic unit. Unit u (0..12, numbered row by row) uses config bits [11u+2:11u] as opcode, [11u+6:11u+3] as A select and [11u+10:11u+7] as B select.
- R7: `res0` takes pool entry cfg[147:143] and `res1` takes pool entry cfg[152:148]. A select of 17 or more gives zero.
- R8: When `valid_in` is low at an edge, `res0` and `res1` keep their values and `valid_out` is low.
- R9: During reset, `valid_out`, `res0` and `res1` are all zero.
- R10: A chain of three dependent additions through rows 0, 2 and 4 gives the wrapped sum of the four inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operation present this cycle |
| cfg | input | 153 | Unit opcodes, crossbar selects and output selects |
| op_a | input | 32 | Source operand, pool index 0 |
| op_b | input | 32 | Source operand, pool index 1 |
| op_c | input | 32 | Source operand, pool index 2 |
| op_d | input | 32 | Source operand, pool index 3 |
| valid_out | output | 1 | Results valid |
| res0 | output | 32 | First result |
| res1 | output | 32 | Second result |

## Verification
The assertions assume that `cfg` and the operands are stable and known at every clock edge where `valid_in` is high. They also assume that reset is asserted before the first operation. The bench changes inputs only on the falling clock edge and never leaves them unknown. It holds reset low for several cycles before it issues any work. Random configuration words cover every select value, including out-of-range ones, so the out-of-pool zero paths are reached without breaking these assumptions.

// File: rtl/subgraph_array.sv
module subgraph_array #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  input  logic [152:0]         cfg,
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic [W-1:0]         op_c,
  input  logic [W-1:0]         op_d,
  output logic                 valid_out,
  output logic [W-1:0]         res0,
  output logic [W-1:0]         res1
);
  localparam int NIN   = 4;
  localparam int NU    = 13;
  localparam int NPOOL = NIN + NU;
  localparam int OPW   = 3;
  localparam int SW    = 4;
  localparam int UW    = OPW + 2 * SW;
  localparam int OSW   = 5;
  localparam int OBASE = NU * UW;

  function automatic int row_of(input int u);
    if (u < 4)  return 0;
    if (u < 8)  return 1;
    if (u < 10) return 2;
    if (u < 12) return 3;
    return 4;
  endfunction

  function automatic int row_first(input int r);
    case (r)
      0: return 0;
      1: return 4;
      2: return 8;
      3: return 10;
      default: return 12;
    endcase
  endfunction

  logic [W-1:0] pool [NPOOL];
  assign pool[0] = op_a;
  assign pool[1] = op_b;
  assign pool[2] = op_c;
  assign pool[3] = op_d;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int LIM   = NIN + row_first(row_of(u));
    localparam bit ARITH = (row_of(u) % 2) == 0;
    logic [OPW-1:0] op;
    logic [SW-1:0]  sa, sb;
    logic [W-1:0]   a, b, y;
    assign op = cfg[u*UW +: OPW];
    assign sa = cfg[u*UW+OPW +: SW];
    assign sb = cfg[u*UW+OPW+SW +: SW];
    assign a  = (int'(sa) < LIM) ? pool[sa] : '0;
    assign b  = (int'(sb) < LIM) ? pool[sb] : '0;
    always_comb begin
      case (op)
        3'd1: y = a & b;
        3'd2: y = a | b;
        3'd3: y = a ^ b;
        3'd4: y = a & ~b;
        3'd5: y = ~a;
        3'd6: y = ARITH ? a + b : a;
        3'd7: y = ARITH ? a - b : a;
        default: y = a;
      endcase
    end
    assign pool[NIN+u] = y;

    if (!ARITH) begin : g_chk
      a_r3_logic_no_arith: assert property (@(posedge clk) disable iff (!rst_n)
        (op[2:1] == 2'b11) |-> (pool[NIN+u] == a));
    end
  end

  logic [OSW-1:0] s0, s1;
  logic [W-1:0]   m0, m1;
  assign s0 = cfg[OBASE +: OSW];
  assign s1 = cfg[OBASE+OSW +: OSW];
  assign m0 = (int'(s0) < NPOOL) ? pool[s0[4:0]] : '0;
  assign m1 = (int'(s1) < NPOOL) ? pool[s1[4:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      res0      <= '0;
      res1      <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        res0 <= m0;
        res1 <= m1;
      end
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(res0) && $stable(res1) && !valid_out));
  a_r1_input_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && cfg[OBASE +: OSW] == 5'd1) |=> (res0 == $past(op_b) && valid_out));
  a_r7_zero_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && cfg[OBASE+OSW +: OSW] >= 5'd17) |=> (res1 == '0));
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && res0 == '0 && res1 == '0));
endmodule

// File: tb/sim_subgraph_array.sv
`timescale 1ns/1ps
module sim_subgraph_array;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [152:0] cfg = '0;
  logic [31:0]  op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic         valid_out;
  logic [31:0]  res0, res1;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic        exp_v = 1'b0;
  logic [31:0] exp0 = '0, exp1 = '0;
  string       exp_tag = "R9";

  always #2 clk = ~clk;

  subgraph_array u0 (.clk(clk), .rst_n(rst_n), .valid_in(valid_in), .cfg(cfg),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .valid_out(valid_out), .res0(res0), .res1(res1));

  function automatic logic [63:0] model(input logic [152:0] c,
      input logic [31:0] i0, input logic [31:0] i1, input logic [31:0] i2, input logic [31:0] i3);
    logic [31:0] v [17];
    int starts [5];
    starts = '{0, 4, 8, 10, 12};
    v[0] = i0; v[1] = i1; v[2] = i2; v[3] = i3;
    for (int u = 0; u < 13; u++) begin
      int r = 0;
      int opc, ia, ib, lim;
      logic [31:0] x, y, z;
      for (int k = 1; k < 5; k++) if (u >= starts[k]) r = k;
      lim = 4 + starts[r];
      opc = int'(c[u*11 +: 3]);
      ia  = int'(c[u*11+3 +: 4]);
      ib  = int'(c[u*11+7 +: 4]);
      x = (ia < lim) ? v[ia] : 32'd0;
      y = (ib < lim) ? v[ib] : 32'd0;
      case (opc)
        1: z = x & y;
        2: z = x | y;
        3: z = x ^ y;
        4: z = x & ~y;
        5: z = ~x;
        6: z = (r % 2 == 0) ? 32'(x + y) : x;
        7: z = (r % 2 == 0) ? 32'(x - y) : x;
        default: z = x;
      endcase
      v[4+u] = z;
    end
    begin
      int o0 = int'(c[143 +: 5]);
      int o1 = int'(c[148 +: 5]);
      model = {(o1 < 17) ? v[o1] : 32'd0, (o0 < 17) ? v[o0] : 32'd0};
    end
  endfunction

  task automatic check_now();
    total++;
    if (valid_out !== exp_v || res0 !== exp0 || res1 !== exp1) begin
      fails++;
      $display("FAIL %s: got v=%b r0=%h r1=%h expected v=%b r0=%h r1=%h",
               exp_tag, valid_out, res0, res1, exp_v, exp0, exp1);
    end
  endtask

  task automatic step(input logic v, input logic [152:0] c,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] d2,
      input logic [31:0] d3, input string tag);
    logic [63:0] m;
    @(negedge clk);
    check_now();
    valid_in = v; cfg = c; op_a = a; op_b = b; op_c = d2; op_d = d3;
    exp_v = v;
    exp_tag = tag;
    if (v) begin
      m = model(c, a, b, d2, d3);
      exp0 = m[31:0];
      exp1 = m[63:32];
    end
  endtask

  function automatic logic [152:0] set_unit(input logic [152:0] c, input int u,
      input int opc, input int sa, input int sb);
    logic [152:0] t = c;
    t[u*11 +: 3]   = 3'(opc);
    t[u*11+3 +: 4] = 4'(sa);
    t[u*11+7 +: 4] = 4'(sb);
    return t;
  endfunction

  function automatic logic [152:0] set_out(input logic [152:0] c, input int o0, input int o1);
    logic [152:0] t = c;
    t[143 +: 5] = 5'(o0);
    t[148 +: 5] = 5'(o1);
    return t;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [152:0] c;
    logic [31:0] w0, w1, w2, w3;
    // R9 reset state
    repeat (3) begin @(negedge clk); check_now(); end
    @(negedge clk); rst_n = 1'b1;

    // R1 default config: every unit passes op_a, outputs pick op_a
    step(1, '0, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444, "R1");
    // R10 and R4: dependent add chain rows 0 -> 2 -> 4 with wraparound
    c = '0;
    c = set_unit(c, 0, 6, 0, 1);
    c = set_unit(c, 4, 0, 4, 0);
    c = set_unit(c, 8, 6, 8, 2);
    c = set_unit(c, 10, 0, 12, 0);
    c = set_unit(c, 12, 6, 14, 3);
    c = set_out(c, 16, 12);
    step(1, c, 32'hFFFFFFFF, 32'h00000002, 32'h80000000, 32'h80000003, "R10");
    // R4 subtract wrap
    c = set_unit('0, 0, 7, 0, 1);
    c = set_out(c, 4, 1);
    step(1, c, 32'h00000001, 32'h00000003, 0, 0, "R4");
    // R3 arithmetic codes on logic-only units pass A
    c = set_unit('0, 4, 6, 1, 2);
    c = set_unit(c, 5, 7, 2, 1);
    c = set_out(c, 8, 9);
    step(1, c, 32'h5, 32'h00000100, 32'h00000020, 32'h7, "R3");
    // R5 out-of-pool selects give zero
    c = set_unit('0, 0, 2, 5, 1);
    c = set_unit(c, 8, 0, 12, 0);
    c = set_out(c, 4, 12);
    step(1, c, 32'hAAAA0000, 32'h0000BBBB, 32'h1, 32'h2, "R5");
    // R7 output select out of range
    c = set_out('0, 17, 31);
    step(1, c, 32'hDEADBEEF, 32'h1, 32'h2, 32'h3, "R7");
    // R2 each opcode on row 0 unit, output 0 pick
    for (int k = 0; k < 8; k++) begin
      c = set_unit('0, 0, k, 2, 3);
      c = set_out(c, 4, 3);
      step(1, c, 0, 0, 32'hF0F0A5A5, 32'h0FF0FFFF, "R2");
    end
    // R8 hold with valid low and changed inputs
    step(0, '1, 32'h12345678, 32'h9, 32'h9, 32'h9, "R8");
    step(0, '0, 32'h0, 32'h0, 32'h0, 32'h0, "R8");
    // R1 R5 R6 R7 random back-to-back with occasional gaps
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < 5; k++) c[k*32 +: 32] = $urandom;
      w0 = $urandom; w1 = $urandom; w2 = $urandom; w3 = $urandom;
      if (n % 4 == 0) begin w0 = 32'hFFFFFFFF; w1 = 32'h1; end
      step(($urandom % 8) != 0, c, w0, w1, w2, w3, "R6 random");
    end
    step(0, '0, 0, 0, 0, 0, "R1");
    @(negedge clk); check_now();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule